// File: doc/BRIEF.md
# Load-Aware Flow-Sticky Queue Selector

This block decides which of several output queues receives each incoming packet descriptor. It watches the fill level of every output buffer on each clock. From those samples it keeps a smoothed average and a smoothed spread per queue. When a descriptor arrives, the block adds the three figures into a single load score per queue and sends new traffic to the queue with the lowest score. A rotating pointer breaks ties, so under even load the choices step through the queues one after another.

Related packets must stay together: all descriptors carrying the same flow key (a folded tuple hash, tunnel identifier, tag or fragment identifier) go to one queue. A small direct-mapped table holds, for each hashed key slot, a valid bit and the queue assigned on first sight. The table is consulted first. A hit reuses the stored queue. A miss runs the load-based choice and records the result. Lengths and fills share one unit (for example 64-byte blocks), so large frames count for what they occupy. A queue that cannot absorb the new packet is not offered to a new flow. When no queue qualifies, the descriptor is dropped and counted.

Top module: `flow_steer`

## Requirements
- R1: After a synchronous active-low reset, `pick_vld` is 0, `drop_cnt` is 0, the rotating pointer is at queue 0, all per-queue averages and spreads are 0, and the flow table is empty, so the first descriptor of any key is a miss (`pick_hit` = 0).
- R2: On every clock out of reset, for each queue q with fill F and stored average A and spread D, A becomes A + ((F − A) >>> EMA_SH) and D becomes D + ((|F − A| − D) >>> EMA_SH). The shifts are arithmetic and the old A is used in both.
- R3: On a table miss, the chosen queue is an eligible queue with the lowest score F + A + D, using the fill presented with the descriptor and the A and D held before that clock.
- R4: Among eligible queues with equal lowest score, the first one found starting at the pointer and counting upward (wrapping) wins. After every delivered descriptor, hit or miss, the pointer becomes (chosen queue + 1) mod NQ. A drop leaves the pointer unchanged.
- R5: With equal scores on all queues and distinct new keys, successive picks rotate 0, 1, 2, ... like plain round robin.
- R6: The table slot is the XOR of all TBL_AW-bit slices of the key (for KEY_W=16, TBL_AW=4: key[3:0]^key[7:4]^key[11:8]^key[15:12]). When that slot is valid, the stored queue is returned with `pick_hit` = 1.
- R7: A miss that delivers writes the chosen queue into the key's slot and marks it valid, so the next descriptor mapping to that slot hits the same queue.
- R8: On a miss, queue q is eligible only when F + length ≤ FULL_TH (equality is eligible). A hit ignores eligibility and uses the stored queue even when that queue is over threshold.
- R9: On a miss with no eligible queue, `pick_drop` = 1, `pick_hit` = 0, `drop_cnt` increments by one (wrapping), and neither the table nor the pointer changes.
- R10: The result for a descriptor presented at clock edge N appears on the outputs after edge N. `pick_vld` follows `desc_vld` one cycle later and is 0 in cycles without a descriptor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| desc_vld | input | 1 | Descriptor present this cycle |
| desc_key | input | KEY_W | Flow key of the descriptor |
| desc_len | input | LEN_W | Packet length in fill units |
| fill_lvl | input | NQ*FILL_W | Fill level of each queue, queue q at bits [q*FILL_W +: FILL_W] |
| pick_vld | output | 1 | Result valid |
| pick_q | output | QW | Chosen queue index |
| pick_hit | output | 1 | Result came from the flow table |
| pick_drop | output | 1 | Descriptor dropped, no eligible queue |
| drop_cnt | output | CNT_W | Number of dropped descriptors |

## Verification
A corrupted average or spread does not show on any port right away. It surfaces only at the next table miss, where the lowest-score queue differs from the reference. Because the smoothing decays slowly, the error can affect many later misses before it fades. A lost or stale table entry shows at the first repeat of the key, as a miss or a different queue. A pointer error shows at the next tie, as a queue out of rotation order. The bench therefore runs long stretches of equal and near-equal fills with a small key pool, so that ties, hits and drops recur within a few cycles of any divergence.

// File: rtl/flow_steer_pkg.sv
// Shared helpers for the flow-sticky queue selector.
// Assumes queue counts small enough to fit an int.
package flow_steer_pkg;

    // Next index on a ring of n entries.
    function automatic int unsigned ring_next(int unsigned v, int unsigned n);
        return (v + 1 >= n) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/fs_load_stats.sv
// Per-queue load statistics: exponential moving average of the fill and
// moving average of the absolute distance between fill and that average.
// Assumes fill is sampled once per clock; shift-and-add only, no multiply.
module fs_load_stats #(
    parameter int FILL_W = 10,
    parameter int EMA_SH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FILL_W-1:0] fill_i,
    output logic [FILL_W-1:0] avg_o,
    output logic [FILL_W-1:0] dev_o
);
    localparam int SW = FILL_W + 2;

    logic [FILL_W-1:0] avg_q, dev_q;
    logic signed [SW-1:0] diff, mag, ddev, avg_sum, dev_sum;

    // Signed steps toward the new sample for average and spread.
    always_comb begin
        diff    = $signed({2'b00, fill_i}) - $signed({2'b00, avg_q});
        mag     = (diff < 0) ? -diff : diff;
        ddev    = mag - $signed({2'b00, dev_q});
        avg_sum = $signed({2'b00, avg_q}) + (diff >>> EMA_SH);
        dev_sum = $signed({2'b00, dev_q}) + (ddev >>> EMA_SH);
    end

    // Register the smoothed figures every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            avg_q <= '0;
            dev_q <= '0;
        end else begin
            avg_q <= avg_sum[FILL_W-1:0];
            dev_q <= dev_sum[FILL_W-1:0];
        end
    end

    assign avg_o = avg_q;
    assign dev_o = dev_q;

    AST_STATS_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_i == avg_q && dev_q == '0) |=> (avg_q == $past(avg_q) && dev_q == '0)); // R2
endmodule

// File: rtl/fs_flow_table.sv
// Direct-mapped flow-to-queue table. The slot is the XOR fold of the key.
// Assumes KEY_W is a multiple of TBL_AW. Read is combinational; write on clock.
module fs_flow_table #(
    parameter int KEY_W  = 16,
    parameter int TBL_AW = 4,
    parameter int QW     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [KEY_W-1:0] key_i,
    output logic             rd_hit,
    output logic [QW-1:0]    rd_q,
    input  logic             wr_en,
    input  logic [QW-1:0]    wr_q
);
    localparam int NT  = 1 << TBL_AW;
    localparam int NSL = KEY_W / TBL_AW;

    logic [TBL_AW-1:0] slot;
    logic [NT-1:0]     vld_q;
    logic [QW-1:0]     q_tbl [NT];

    // Fold the key into a table slot.
    always_comb begin
        slot = '0;
        for (int s = 0; s < NSL; s++) slot ^= key_i[s*TBL_AW +: TBL_AW];
    end

    assign rd_hit = vld_q[slot];
    assign rd_q   = q_tbl[slot];

    // Valid bits, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     vld_q       <= '0;
        else if (wr_en) vld_q[slot] <= 1'b1;
    end

    // Stored queue indices, meaningful only where valid.
    always_ff @(posedge clk) begin
        if (wr_en) q_tbl[slot] <= wr_q;
    end

    AST_TBL_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !rd_hit); // R7
endmodule

// File: rtl/fs_pick.sv
// Combinational chooser: lowest fill+average+spread among queues that can
// take the packet, ties broken by first index at or after the pointer.
// Assumes ptr_i < NQ.
module fs_pick #(
    parameter int NQ      = 4,
    parameter int FILL_W  = 10,
    parameter int LEN_W   = 8,
    parameter int FULL_TH = 800,
    parameter int QW      = 2
) (
    input  logic [NQ*FILL_W-1:0] fill_i,
    input  logic [NQ*FILL_W-1:0] avg_i,
    input  logic [NQ*FILL_W-1:0] dev_i,
    input  logic [LEN_W-1:0]     len_i,
    input  logic [QW-1:0]        ptr_i,
    output logic                 any_ok,
    output logic [QW-1:0]        sel_o
);
    localparam int SCW = FILL_W + 2;

    logic [SCW-1:0] best, sc;
    int idx;

    // Walk the ring from the pointer, keeping the strictly lower score.
    always_comb begin
        any_ok = 1'b0;
        sel_o  = '0;
        best   = '0;
        sc     = '0;
        idx    = 0;
        for (int k = 0; k < NQ; k++) begin
            idx = int'(ptr_i) + k;
            if (idx >= NQ) idx = idx - NQ;
            sc = {2'b00, fill_i[idx*FILL_W +: FILL_W]}
               + {2'b00, avg_i[idx*FILL_W +: FILL_W]}
               + {2'b00, dev_i[idx*FILL_W +: FILL_W]};
            if (int'(fill_i[idx*FILL_W +: FILL_W]) + int'(len_i) <= FULL_TH) begin
                if (!any_ok || sc < best) begin
                    any_ok = 1'b1;
                    best   = sc;
                    sel_o  = QW'(idx);
                end
            end
        end
    end
endmodule

// File: rtl/flow_steer.sv
// Top of the flow-sticky, load-aware queue selector. One descriptor per
// clock; result registered one cycle later. Table first, load score second.
// Assumes fill and length use the same unit.
module flow_steer #(
    parameter int NQ      = 4,
    parameter int FILL_W  = 10,
    parameter int LEN_W   = 8,
    parameter int KEY_W   = 16,
    parameter int TBL_AW  = 4,
    parameter int EMA_SH  = 3,
    parameter int FULL_TH = 800,
    parameter int CNT_W   = 16,
    localparam int QW     = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 desc_vld,
    input  logic [KEY_W-1:0]     desc_key,
    input  logic [LEN_W-1:0]     desc_len,
    input  logic [NQ*FILL_W-1:0] fill_lvl,
    output logic                 pick_vld,
    output logic [QW-1:0]        pick_q,
    output logic                 pick_hit,
    output logic                 pick_drop,
    output logic [CNT_W-1:0]     drop_cnt
);
    import flow_steer_pkg::*;

    logic [NQ*FILL_W-1:0] avg_flat, dev_flat;
    logic                 tbl_hit, any_ok, tbl_wr;
    logic [QW-1:0]        tbl_q, sel_q, ptr_q;

    // One statistics tracker per queue.
    for (genvar g = 0; g < NQ; g++) begin : g_stats
        fs_load_stats #(.FILL_W(FILL_W), .EMA_SH(EMA_SH)) u_stats (
            .clk    (clk),
            .rst_n  (rst_n),
            .fill_i (fill_lvl[g*FILL_W +: FILL_W]),
            .avg_o  (avg_flat[g*FILL_W +: FILL_W]),
            .dev_o  (dev_flat[g*FILL_W +: FILL_W])
        );
    end

    fs_flow_table #(.KEY_W(KEY_W), .TBL_AW(TBL_AW), .QW(QW)) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .key_i  (desc_key),
        .rd_hit (tbl_hit),
        .rd_q   (tbl_q),
        .wr_en  (tbl_wr),
        .wr_q   (sel_q)
    );

    fs_pick #(.NQ(NQ), .FILL_W(FILL_W), .LEN_W(LEN_W), .FULL_TH(FULL_TH), .QW(QW)) u_pick (
        .fill_i (fill_lvl),
        .avg_i  (avg_flat),
        .dev_i  (dev_flat),
        .len_i  (desc_len),
        .ptr_i  (ptr_q),
        .any_ok (any_ok),
        .sel_o  (sel_q)
    );

    // Record a new flow only when a queue was actually assigned.
    assign tbl_wr = desc_vld && !tbl_hit && any_ok;

    // Register the decision, advance the pointer, count drops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pick_vld  <= 1'b0;
            pick_q    <= '0;
            pick_hit  <= 1'b0;
            pick_drop <= 1'b0;
            drop_cnt  <= '0;
            ptr_q     <= '0;
        end else begin
            pick_vld  <= desc_vld;
            pick_hit  <= 1'b0;
            pick_drop <= 1'b0;
            if (desc_vld) begin
                if (tbl_hit) begin
                    pick_q   <= tbl_q;
                    pick_hit <= 1'b1;
                    ptr_q    <= QW'(ring_next(int'(tbl_q), NQ));
                end else if (any_ok) begin
                    pick_q <= sel_q;
                    ptr_q  <= QW'(ring_next(int'(sel_q), NQ));
                end else begin
                    pick_q    <= '0;
                    pick_drop <= 1'b1;
                    drop_cnt  <= drop_cnt + 1'b1;
                end
            end
        end
    end

    AST_PICK_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        desc_vld |=> pick_vld); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !desc_vld |=> !pick_vld); // R10
    AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_vld && !pick_drop) |-> (ptr_q == QW'(ring_next(int'(pick_q), NQ)))); // R4
    AST_DROP_NOT_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        pick_drop |-> (pick_vld && !pick_hit)); // R9
    AST_DROP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_vld && pick_drop) |-> (drop_cnt == $past(drop_cnt) + 1'b1)); // R9
    AST_DROP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(pick_vld && pick_drop) |-> $stable(drop_cnt)); // R9
endmodule

// File: tb/flow_steer_bench.sv
// Bench for flow_steer: directed corners plus seeded random traffic,
// compared against a reference model built from the requirements.
module flow_steer_bench;
    localparam int NQ = 4, FW = 10, LW = 8, KW = 16, AW = 4, SH = 3, TH = 800, CW = 16;
    localparam int NT = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic desc_vld = 1'b0;
    logic [KW-1:0] desc_key = '0;
    logic [LW-1:0] desc_len = '0;
    logic [NQ*FW-1:0] fill_lvl = '0;
    logic pick_vld, pick_hit, pick_drop;
    logic [1:0] pick_q;
    logic [CW-1:0] drop_cnt;

    always #2.5 clk = ~clk;

    flow_steer u_flow_steer (
        .clk(clk), .rst_n(rst_n), .desc_vld(desc_vld), .desc_key(desc_key),
        .desc_len(desc_len), .fill_lvl(fill_lvl), .pick_vld(pick_vld),
        .pick_q(pick_q), .pick_hit(pick_hit), .pick_drop(pick_drop), .drop_cnt(drop_cnt)
    );

    int checks = 0, errors = 0;
    int fl[NQ], avg_m[NQ], dev_m[NQ];
    bit tv[NT];
    int tq[NT];
    int ptr_m = 0, dcnt_m = 0;
    bit have_exp = 0, e_vld, e_hit, e_drop;
    int e_q;
    string e_tag;

    function automatic int slot_of(int key);
        return (key ^ (key >> 4) ^ (key >> 8) ^ (key >> 12)) & (NT - 1);
    endfunction

    function automatic void stats_step();
        for (int q = 0; q < NQ; q++) begin
            int d = fl[q] - avg_m[q];
            int ad = (d < 0) ? -d : d;
            avg_m[q] = avg_m[q] + (d >>> SH);
            dev_m[q] = dev_m[q] + ((ad - dev_m[q]) >>> SH);
        end
    endfunction

    task automatic check_pending();
        if (!have_exp) return;
        checks++;
        if (pick_vld !== e_vld || (e_vld && (pick_hit !== e_hit || pick_drop !== e_drop
            || (!e_drop && pick_q !== 2'(e_q)) || drop_cnt !== CW'(dcnt_m)))) begin
            errors++;
            $display("FAIL %s: vld=%0d hit=%0d drop=%0d q=%0d cnt=%0d expected vld=%0d hit=%0d drop=%0d q=%0d cnt=%0d",
                e_tag, pick_vld, pick_hit, pick_drop, pick_q, drop_cnt,
                e_vld, e_hit, e_drop, e_q, dcnt_m);
        end
    endtask

    // One cycle: check last result, drive new inputs, predict the outcome.
    task automatic cyc(bit v, int key, int len, string tag);
        @(negedge clk);
        check_pending();
        for (int q = 0; q < NQ; q++) fill_lvl[q*FW +: FW] = FW'(fl[q]);
        desc_vld = v;
        desc_key = KW'(key);
        desc_len = LW'(len);
        e_vld = v; e_hit = 0; e_drop = 0; e_q = 0;
        if (v) begin
            int s = slot_of(key);
            if (tv[s]) begin
                e_hit = 1; e_q = tq[s];
                ptr_m = (e_q + 1) % NQ;
            end else begin
                int best = -1, bs = 0;
                for (int k = 0; k < NQ; k++) begin
                    int i = (ptr_m + k) % NQ;
                    int sc = fl[i] + avg_m[i] + dev_m[i];
                    if (fl[i] + len <= TH && (best < 0 || sc < bs)) begin
                        best = i; bs = sc;
                    end
                end
                if (best < 0) begin
                    e_drop = 1; dcnt_m = (dcnt_m + 1) & 16'hffff;
                end else begin
                    e_q = best; tv[s] = 1; tq[s] = best;
                    ptr_m = (best + 1) % NQ;
                end
            end
        end
        if (tag != "") e_tag = tag;
        else e_tag = !v ? "R10" : e_hit ? "R6" : e_drop ? "R9" : "R3";
        stats_step();
        have_exp = 1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        check_pending();
        have_exp = 0;
        rst_n = 0; desc_vld = 0;
        repeat (3) @(negedge clk);
        checks++;
        if (pick_vld !== 1'b0 || drop_cnt !== '0) begin
            errors++;
            $display("FAIL R1: vld=%0d cnt=%0d expected vld=0 cnt=0", pick_vld, drop_cnt);
        end
        for (int q = 0; q < NQ; q++) begin avg_m[q] = 0; dev_m[q] = 0; end
        for (int s = 0; s < NT; s++) tv[s] = 0;
        ptr_m = 0; dcnt_m = 0;
        for (int q = 0; q < NQ; q++) fill_lvl[q*FW +: FW] = FW'(fl[q]);
        rst_n = 1;
        e_vld = 0; e_tag = "R1";
        stats_step();
        have_exp = 1;
    endtask

    task automatic set_fill(int a, int b, int c, int d);
        fl[0] = a; fl[1] = b; fl[2] = c; fl[3] = d;
    endtask

    task automatic run();
        void'($urandom(32'd1234));
        set_fill(0, 0, 0, 0);
        do_reset();
        // Even load, fresh keys: round robin from queue 0.
        for (int i = 0; i < 4; i++) cyc(1, i, 10, "R5 R4");
        cyc(1, 9, 10, "R5 R4");
        // Repeat of a known key reuses its queue.
        set_fill(0, 700, 0, 0);
        cyc(1, 1, 10, "R6 R7");
        cyc(0, 0, 0, "R10");
        // One clearly lighter queue wins a new flow.
        set_fill(500, 100, 500, 500);
        cyc(1, 5, 10, "R3 R2");
        // Nothing can take the packet: drop, no table write.
        set_fill(790, 900, 790, 790);
        cyc(1, 6, 20, "R9");
        cyc(1, 6, 20, "R9");
        // Known flow still goes to its queue while over threshold.
        cyc(1, 1, 20, "R8");
        // Exactly at threshold is eligible.
        set_fill(790, 900, 780, 790);
        cyc(1, 7, 20, "R8");
        cyc(1, 7, 20, "R7");
        // Reset clears the table: a known key misses again.
        do_reset();
        set_fill(0, 0, 0, 0);
        cyc(1, 1, 10, "R1");
        // Seeded random traffic.
        for (int n = 0; n < 4000; n++) begin
            if (n % 16 == 0) begin
                int mode = $urandom_range(0, 2);
                int base = $urandom_range(0, 600);
                for (int q = 0; q < NQ; q++)
                    fl[q] = (mode == 0) ? base : (mode == 1) ? $urandom_range(0, 1023)
                                                             : $urandom_range(780, 1023);
            end
            if (n % 1000 == 999) do_reset();
            else cyc($urandom_range(0, 3) != 0, ($urandom_range(0, 31) * 977) & 16'hffff,
                     $urandom_range(1, 255), "");
        end
        cyc(0, 0, 0, "R10");
        @(negedge clk);
        check_pending();
        have_exp = 0;
    endtask

    initial begin
        fork
            run();
            begin
                repeat (200000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule